// File: doc/BRIEF.md
# Interrupt Distributor with 16-Bit CPU Targets

This block gathers interrupt lines and holds, for every interrupt ID, its enable, pending, active and trigger state. It forwards each interrupt that is pending and enabled to the CPU interfaces named in its target field. IDs 0 to 31 are private: each CPU interface has its own copy of their enable, pending and active bits. IDs 0 to 15 are raised only by software, either through the software-interrupt register or through a pending-set write. IDs 16 to 31 come from a per-CPU input bundle. IDs 32 and up are shared lines, and each one is steered by a 16-bit CPU mask.

Software reaches the block over a plain 32-bit register port. One access is made per cycle. A read or write is qualified by a strobe and carries a byte address and the ID of the requesting CPU. Read data appears on the cycle after the read strobe and is held until the next read. There is no back-pressure: every access completes in one cycle. The output to each CPU interface is a vector with one request bit for each ID, plus an OR-reduced request line.

Top module: `irq_dist`

## Requirements
- R1: The word at byte address 0x004 reports, in bits 4:0, the value NUM_IRQ/32-1. IDs at or above min(NUM_IRQ,510) are unimplemented: writes to them are ignored and they read as 0.
- R2: Enable-set is at 0x100 and enable-clear is at 0x180, each plus (ID/32)*4, with bit ID%32. Writing a 1 sets or clears that enable bit. Writing a 0 leaves it unchanged. Both addresses read back the current enables.
- R3: The target word of an ID is at 0x800 + ((ID*2) with bits 1:0 cleared). An even ID uses bits 15:0 and an odd ID uses bits 31:16. Bit c of the mask selects CPU interface c. For shared IDs the mask reads back as written.
- R4: For IDs 0 to 31, the enable, pending and active bits seen and changed through the register port belong to the requesting CPU only.
- R5: Reading a target word that covers IDs 0 to 31 returns the requester's one-hot mask (1<<cpu) in both halves. Writes to those words are ignored.
- R6: Writing 0xF00 sets pending for ID wdata[3:0] on every CPU c whose bit wdata[8+c] is 1. This 16-bit map starts at bit 8.
- R7: Bit 0 of the control word at 0x000 enables forwarding. It resets to 0. While it is 0, every cpu_req and cpu_irq bit is 0, and pending state is kept.
- R8: Trigger fields are at 0xC00 + (ID/16)*4, two bits per ID at bit 2*(ID%16). The value 2'b10 selects rising edge and 2'b00 selects active-high level. Writes to IDs 0 to 15 are ignored, and those IDs read 2'b10. For shared IDs, a field whose bit 0 is 1 is ignored. For IDs 16 to 31, bit 1 alone selects the mode. Every mode resets to level.
- R9: An edge-mode ID becomes pending on a rising input edge and stays pending after the input falls. Pending-set is at 0x200 and pending-clear at 0x280, each plus (ID/32)*4, with write-1 semantics. Reads at 0x200 or 0x280 return pending.
- R10: A level-mode ID is pending exactly while its input is 1 and its active bit is 0. Active-set is at 0x300 and active-clear at 0x380, with write-1 semantics. Pending-set writes have no effect on a level-mode ID.
- R11: cpu_req[c*NUM_IRQ+ID] is 1 when forwarding is on and the ID is pending, enabled and targeted at CPU c. A private ID targets only its own CPU. cpu_irq[c] is the OR of CPU c's request bits.
- R12: Read data for an access made in cycle t appears on bus_rdata from cycle t+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 12 | Byte address |
| bus_cpu | input | 4 | Requesting CPU interface number |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| spi_in | input | NUM_IRQ-32 | Shared interrupt lines, bit i is ID 32+i |
| ppi_in | input | NCPU*16 | Private lines, bit c*16+j is ID 16+j of CPU c |
| cpu_req | output | NCPU*NUM_IRQ | Per-CPU, per-ID forwarded requests |
| cpu_irq | output | NCPU | Per-CPU request summary |

## Verification
The bench builds the block with NUM_IRQ=64 and NCPU=4, the default values. This keeps two bit-per-ID words, sixteen private target words and thirty-two shared target entries. That makes it practical to sweep every target word from every CPU and every non-zero software-interrupt map over four interfaces. At this size, edge and level triggering, banking and the forwarding gate can also be checked on individual IDs against values the bench computes from the address arithmetic.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;

  typedef enum logic [3:0] {
    RG_NONE, RG_CTRL, RG_TYPE, RG_ENS, RG_ENC, RG_PDS, RG_PDC,
    RG_ACS, RG_ACC, RG_TGT, RG_CFG, RG_SWI
  } region_e;

  localparam logic [1:0] CFG_LEVEL = 2'b00;
  localparam logic [1:0] CFG_EDGE  = 2'b10;

  function automatic region_e decode(input logic [11:0] a);
    region_e r;
    r = RG_NONE;
    if (a == 12'h000)            r = RG_CTRL;
    else if (a == 12'h004)       r = RG_TYPE;
    else if (a == 12'hF00)       r = RG_SWI;
    else if (a[11:10] == 2'b10)  r = RG_TGT;
    else if (a[11:8] == 4'hC)    r = RG_CFG;
    else if (a[11:10] == 2'b00) begin
      case (a[9:7])
        3'd2: r = RG_ENS;
        3'd3: r = RG_ENC;
        3'd4: r = RG_PDS;
        3'd5: r = RG_PDC;
        3'd6: r = RG_ACS;
        3'd7: r = RG_ACC;
        default: r = RG_NONE;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/irq_dist_pend.sv
module irq_dist_pend #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] line_i,
  input  logic [W-1:0] edge_i,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] act_i,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] prev_q, pend_q, rise;

  assign rise = edge_i & line_i & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= line_i;
      pend_q <= ((pend_q & ~clr_i) | set_i | rise) & edge_i;
    end
  end

  assign pend_o = (pend_q & edge_i) | (line_i & ~act_i & ~edge_i);

  // R9: a rising edge in edge mode leaves the bit pending
  p_edge_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((pend_q & $past(rise)) == $past(rise)));

  // R9: a clear with no competing set or edge drops the bit
  p_clear_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~set_i & ~rise)) |=> ((pend_q & $past(clr_i & ~set_i & ~rise)) == '0));
endmodule

// File: rtl/irq_dist_route.sv
module irq_dist_route #(
  parameter int NUM_IRQ = 64,
  parameter int NCPU    = 4
) (
  input  logic                     fwd_en,
  input  logic [NCPU*32-1:0]       pv_pend,
  input  logic [NCPU*32-1:0]       pv_en,
  input  logic [NUM_IRQ-33:0]      sh_pend,
  input  logic [NUM_IRQ-33:0]      sh_en,
  input  logic [(NUM_IRQ-32)*16-1:0] sh_tgt,
  output logic [NCPU*NUM_IRQ-1:0]  cpu_req,
  output logic [NCPU-1:0]          cpu_irq
);
  localparam int NSPI = NUM_IRQ - 32;

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    assign cpu_req[c*NUM_IRQ +: 32] =
      {32{fwd_en}} & pv_pend[c*32 +: 32] & pv_en[c*32 +: 32];
    for (genvar i = 0; i < NSPI; i++) begin : g_spi
      assign cpu_req[c*NUM_IRQ + 32 + i] = fwd_en & sh_pend[i] & sh_en[i] & sh_tgt[i*16 + c];
    end
    assign cpu_irq[c] = |cpu_req[c*NUM_IRQ +: NUM_IRQ];
  end
endmodule

// File: rtl/irq_dist.sv
module irq_dist
  import irq_dist_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int NCPU    = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_rd,
  input  logic                    bus_wr,
  input  logic [11:0]             bus_addr,
  input  logic [3:0]              bus_cpu,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  input  logic [NUM_IRQ-33:0]     spi_in,
  input  logic [NCPU*16-1:0]      ppi_in,
  output logic [NCPU*NUM_IRQ-1:0] cpu_req,
  output logic [NCPU-1:0]         cpu_irq
);
  localparam int NSPI   = NUM_IRQ - 32;
  localparam int NWORD  = NUM_IRQ / 32;
  localparam int NLINES = (NUM_IRQ > 510) ? 510 : NUM_IRQ;
  localparam logic [4:0] TYPE_N = 5'(NWORD - 1);

  region_e rg;
  logic [4:0] wword;
  logic [7:0] tword;
  logic [5:0] cword;
  logic       cpu_ok;
  int         own;
  logic [15:0] own_hot;

  assign rg      = decode(bus_addr);
  assign wword   = bus_addr[6:2];
  assign tword   = bus_addr[9:2];
  assign cword   = bus_addr[7:2];
  assign own     = int'(bus_cpu);
  assign cpu_ok  = own < NCPU;
  assign own_hot = cpu_ok ? (16'd1 << bus_cpu) : 16'd0;

  // state
  logic                 ctrl_en;
  logic [NSPI-1:0]      sh_en, sh_act, sh_edge, sh_pend;
  logic [NSPI*16-1:0]   sh_tgt;
  logic [15:0]          ppi_edge;
  logic [31:0]          pv_en   [NCPU];
  logic [31:0]          pv_act  [NCPU];
  logic [31:0]          pv_pend [NCPU];

  // write mask over all IDs, restricted to implemented ones
  logic [NUM_IRQ-1:0] impl, wmask;
  always_comb begin
    for (int id = 0; id < NUM_IRQ; id++) impl[id] = (id < NLINES);
    wmask = '0;
    if (int'(wword) < NWORD) wmask[int'(wword)*32 +: 32] = bus_wdata;
    wmask = wmask & impl;
  end

  // register updates
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en  <= 1'b0;
      sh_en    <= '0;
      sh_act   <= '0;
      sh_edge  <= '0;
      sh_tgt   <= '0;
      ppi_edge <= '0;
      for (int c = 0; c < NCPU; c++) begin
        pv_en[c]  <= '0;
        pv_act[c] <= '0;
      end
    end else if (bus_wr) begin
      case (rg)
        RG_CTRL: ctrl_en <= bus_wdata[0];
        RG_ENS: begin
          sh_en <= sh_en | wmask[NUM_IRQ-1:32];
          if (cpu_ok) pv_en[own] <= pv_en[own] | wmask[31:0];
        end
        RG_ENC: begin
          sh_en <= sh_en & ~wmask[NUM_IRQ-1:32];
          if (cpu_ok) pv_en[own] <= pv_en[own] & ~wmask[31:0];
        end
        RG_ACS: begin
          sh_act <= sh_act | wmask[NUM_IRQ-1:32];
          if (cpu_ok) pv_act[own] <= pv_act[own] | wmask[31:0];
        end
        RG_ACC: begin
          sh_act <= sh_act & ~wmask[NUM_IRQ-1:32];
          if (cpu_ok) pv_act[own] <= pv_act[own] & ~wmask[31:0];
        end
        RG_TGT: begin
          for (int i = 0; i < NSPI; i++) begin
            if ((int'(tword) == (32 + i) / 2) && (32 + i < NLINES))
              sh_tgt[i*16 +: 16] <= i[0] ? bus_wdata[31:16] : bus_wdata[15:0];
          end
        end
        RG_CFG: begin
          if (cword == 6'd1)
            for (int j = 0; j < 16; j++) ppi_edge[j] <= bus_wdata[2*j+1];
          for (int i = 0; i < NSPI; i++) begin
            if ((int'(cword) == (32 + i) / 16) && (32 + i < NLINES) && !bus_wdata[2*(i%16)])
              sh_edge[i] <= bus_wdata[2*(i%16)+1];
          end
        end
        default: ;
      endcase
    end
  end

  // pending set/clear strobes
  logic [31:0]     pv_set [NCPU];
  logic [31:0]     pv_clr [NCPU];
  logic [NSPI-1:0] sh_set, sh_clr;
  always_comb begin
    sh_set = (bus_wr && rg == RG_PDS) ? wmask[NUM_IRQ-1:32] : '0;
    sh_clr = (bus_wr && rg == RG_PDC) ? wmask[NUM_IRQ-1:32] : '0;
    for (int c = 0; c < NCPU; c++) begin
      pv_set[c] = (bus_wr && rg == RG_PDS && own == c) ? wmask[31:0] : 32'd0;
      pv_clr[c] = (bus_wr && rg == RG_PDC && own == c) ? wmask[31:0] : 32'd0;
      if (bus_wr && rg == RG_SWI && bus_wdata[8+c])
        pv_set[c] = pv_set[c] | (32'd1 << bus_wdata[3:0]);
    end
  end

  irq_dist_pend #(.W(NSPI)) i_sh_pend (
    .clk(clk), .rst_n(rst_n), .line_i(spi_in), .edge_i(sh_edge),
    .set_i(sh_set), .clr_i(sh_clr), .act_i(sh_act), .pend_o(sh_pend)
  );

  logic [NCPU*32-1:0] pv_pend_f, pv_en_f;
  for (genvar c = 0; c < NCPU; c++) begin : g_priv
    irq_dist_pend #(.W(32)) i_pv_pend (
      .clk(clk), .rst_n(rst_n),
      .line_i({ppi_in[c*16 +: 16], 16'd0}),
      .edge_i({ppi_edge, 16'hFFFF}),
      .set_i(pv_set[c]), .clr_i(pv_clr[c]), .act_i(pv_act[c]),
      .pend_o(pv_pend[c])
    );
    assign pv_pend_f[c*32 +: 32] = pv_pend[c];
    assign pv_en_f[c*32 +: 32]   = pv_en[c];

    // R6: a software interrupt aimed at this CPU becomes pending
    p_swi_pends_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && rg == RG_SWI && bus_wdata[8+c]) |=> pv_pend[c][$past(bus_wdata[3:0])]);
  end

  irq_dist_route #(.NUM_IRQ(NUM_IRQ), .NCPU(NCPU)) i_route (
    .fwd_en(ctrl_en), .pv_pend(pv_pend_f), .pv_en(pv_en_f),
    .sh_pend(sh_pend), .sh_en(sh_en), .sh_tgt(sh_tgt),
    .cpu_req(cpu_req), .cpu_irq(cpu_irq)
  );

  // read path: requester's view over all IDs
  logic [NUM_IRQ-1:0] v_en, v_pend, v_act;
  logic [31:0] rd_mux;
  always_comb begin
    v_en   = {sh_en,   cpu_ok ? pv_en[own]   : 32'd0} & impl;
    v_pend = {sh_pend, cpu_ok ? pv_pend[own] : 32'd0} & impl;
    v_act  = {sh_act,  cpu_ok ? pv_act[own]  : 32'd0} & impl;
    rd_mux = '0;
    case (rg)
      RG_CTRL: rd_mux[0] = ctrl_en;
      RG_TYPE: rd_mux[4:0] = TYPE_N;
      RG_ENS, RG_ENC: if (int'(wword) < NWORD) rd_mux = v_en[int'(wword)*32 +: 32];
      RG_PDS, RG_PDC: if (int'(wword) < NWORD) rd_mux = v_pend[int'(wword)*32 +: 32];
      RG_ACS, RG_ACC: if (int'(wword) < NWORD) rd_mux = v_act[int'(wword)*32 +: 32];
      RG_TGT: begin
        for (int h = 0; h < 2; h++) begin
          if (int'(tword)*2 + h < 32)
            rd_mux[h*16 +: 16] = own_hot;
          else if (int'(tword)*2 + h < NLINES)
            rd_mux[h*16 +: 16] = sh_tgt[(int'(tword)*2 + h - 32)*16 +: 16];
        end
      end
      RG_CFG: begin
        for (int k = 0; k < 16; k++) begin
          if (int'(cword)*16 + k < 16)
            rd_mux[2*k +: 2] = CFG_EDGE;
          else if (int'(cword)*16 + k < 32)
            rd_mux[2*k +: 2] = {ppi_edge[k], 1'b0};
          else if (int'(cword)*16 + k < NLINES)
            rd_mux[2*k +: 2] = {sh_edge[int'(cword)*16 + k - 32], 1'b0};
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R7: forwarding off means no CPU sees a request
  p_gate_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |-> (cpu_irq == '0));

  // R2: set bits of the first shared enable word stick
  p_en_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && rg == RG_ENS && wword == 5'd1)
      |=> ((sh_en[31:0] & $past(bus_wdata)) == $past(bus_wdata)));

  // R5: private target words read back the requester's own bit
  p_tgt_own_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && rg == RG_TGT && tword < 8'd16 && cpu_ok)
      |=> (bus_rdata == {$past(own_hot), $past(own_hot)}));

  // R1, R12: identification word appears on the following cycle
  p_type_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && rg == RG_TYPE) |=> (bus_rdata == {27'd0, TYPE_N}));
endmodule

// File: tb/test_irq_dist.sv
module test_irq_dist;
  localparam int NUM_IRQ = 64;
  localparam int NCPU    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [3:0]  bus_cpu = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NUM_IRQ-33:0] spi_in = '0;
  logic [NCPU*16-1:0]  ppi_in = '0;
  logic [NCPU*NUM_IRQ-1:0] cpu_req;
  logic [NCPU-1:0] cpu_irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5ns clk = ~clk;

  irq_dist #(.NUM_IRQ(NUM_IRQ), .NCPU(NCPU)) i_irq_dist (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_cpu(bus_cpu), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .spi_in(spi_in), .ppi_in(ppi_in),
    .cpu_req(cpu_req), .cpu_irq(cpu_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int cpu, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_cpu = 4'(cpu); bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int cpu, input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_cpu = 4'(cpu); bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [15:0] tv(input int id);
    return 16'(id * 291) ^ 16'h5A5A;
  endfunction

  function automatic logic [31:0] req_col(input int id);
    logic [31:0] v = '0;
    for (int c = 0; c < NCPU; c++) v[c] = cpu_req[c*NUM_IRQ + id];
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    chk("R7 reset irq", 32'(cpu_irq), 32'd0);
    rd(0, 12'h000, d); chk("R7 reset ctrl", d, 32'd0);
    rd(0, 12'h004, d); chk("R1 type", d, 32'd1);
    rd(0, 12'h108, d); chk("R1 unimpl word", d, 32'd0);
    wr(0, 12'h000, 32'd1);
    rd(0, 12'h000, d); chk("R7 ctrl on", d, 32'd1);

    // R2 enable set/clear on shared word 1
    wr(0, 12'h104, 32'hFFFF_FFFF);
    rd(0, 12'h104, d); chk("R2 set", d, 32'hFFFF_FFFF);
    wr(0, 12'h184, 32'h0000_FFFF);
    rd(0, 12'h184, d); chk("R2 clr", d, 32'hFFFF_0000);
    wr(0, 12'h104, 32'h0);
    rd(0, 12'h104, d); chk("R2 zero no effect", d, 32'hFFFF_0000);
    wr(0, 12'h184, 32'h0);
    rd(0, 12'h104, d); chk("R2 zero clr no effect", d, 32'hFFFF_0000);
    wr(0, 12'h104, 32'hFFFF_FFFF);

    // R3 sweep shared target words
    for (int w = 16; w < 32; w++)
      wr(w % 4, 12'(12'h800 + w*4), {tv(2*w+1), tv(2*w)});
    for (int w = 16; w < 32; w++) begin
      rd(w % 3, 12'(12'h800 + w*4), d);
      chk("R3 target rb", d, {tv(2*w+1), tv(2*w)});
    end

    // R5 private target words, writes ignored
    wr(1, 12'h800, 32'hFFFF_FFFF);
    for (int c = 0; c < NCPU; c++)
      for (int w = 0; w < 16; w++) begin
        rd(c, 12'(12'h800 + w*4), d);
        chk("R5 own mask", d, {2{16'(1 << c)}});
      end

    // R8 trigger configuration
    wr(0, 12'hC00, 32'hFFFF_FFFF);
    rd(0, 12'hC00, d); chk("R8 sgi cfg", d, 32'hAAAA_AAAA);
    rd(0, 12'hC04, d); chk("R8 ppi reset", d, 32'h0);
    rd(0, 12'hC08, d); chk("R8 spi reset", d, 32'h0);
    wr(0, 12'hC08, 32'hAAAA_AAAA);
    rd(0, 12'hC08, d); chk("R8 spi edge", d, 32'hAAAA_AAAA);
    wr(0, 12'hC08, 32'h5555_5555);
    rd(0, 12'hC08, d); chk("R8 bad code 01", d, 32'hAAAA_AAAA);
    wr(0, 12'hC08, 32'hFFFF_FFFF);
    rd(0, 12'hC08, d); chk("R8 bad code 11", d, 32'hAAAA_AAAA);
    wr(0, 12'hC08, 32'h0);
    rd(0, 12'hC08, d); chk("R8 spi level", d, 32'h0);
    wr(0, 12'hC04, 32'h3);
    rd(0, 12'hC04, d); chk("R8 ppi bit1", d, 32'h2);
    wr(0, 12'hC04, 32'h0);

    // R9 edge-mode ID 40 targeted at CPU 2
    wr(0, 12'hC08, 32'h0002_0000);
    wr(0, 12'h850, 32'h0000_0004);
    chk("R11 idle", 32'(cpu_irq), 32'd0);
    @(negedge clk); spi_in[8] = 1'b1;
    @(negedge clk); spi_in[8] = 1'b0;
    chk("R9 edge latch", req_col(40), 32'h4);
    @(negedge clk);
    chk("R9 held after fall", req_col(40), 32'h4);
    rd(0, 12'h204, d); chk("R9 pend read", d, 32'h100);
    wr(0, 12'h000, 32'h0);
    chk("R7 gate off", 32'(cpu_irq), 32'd0);
    rd(0, 12'h204, d); chk("R7 pend kept", d, 32'h100);
    wr(0, 12'h000, 32'h1);
    chk("R11 route cpu2", 32'(cpu_irq), 32'h4);
    wr(0, 12'h284, 32'h100);
    chk("R9 pend clr", 32'(cpu_irq), 32'd0);
    wr(0, 12'h204, 32'h100);
    chk("R9 pend set", req_col(40), 32'h4);
    wr(0, 12'h184, 32'h100);
    chk("R11 disabled", 32'(cpu_irq), 32'd0);
    wr(0, 12'h104, 32'h100);
    wr(0, 12'h284, 32'h100);
    chk("R9 clr again", 32'(cpu_irq), 32'd0);

    // R10 level-mode ID 33 targeted at CPUs 1 and 3
    wr(0, 12'h840, 32'h000A_0000);
    @(negedge clk); spi_in[1] = 1'b1;
    @(negedge clk);
    chk("R10 level high", 32'(cpu_irq), 32'hA);
    wr(2, 12'h304, 32'h2);
    chk("R10 active masks", 32'(cpu_irq), 32'd0);
    rd(0, 12'h204, d); chk("R10 pend while active", d, 32'h0);
    wr(2, 12'h384, 32'h2);
    chk("R10 active clr", 32'(cpu_irq), 32'hA);
    @(negedge clk); spi_in[1] = 1'b0;
    @(negedge clk);
    chk("R10 level low", 32'(cpu_irq), 32'd0);
    wr(0, 12'h204, 32'h2);
    chk("R10 set ignored", 32'(cpu_irq), 32'd0);

    // R4 banked private enables
    for (int c = 0; c < NCPU; c++) wr(c, 12'h100, 32'hFFFF_FFFF);
    wr(0, 12'h180, 32'h1);
    rd(0, 12'h100, d); chk("R4 cpu0 en", d, 32'hFFFF_FFFE);
    rd(1, 12'h100, d); chk("R4 cpu1 en", d, 32'hFFFF_FFFF);
    wr(0, 12'h100, 32'h1);

    // R6 software-interrupt sweep over all non-zero maps
    for (int m = 1; m < 16; m++) begin
      wr(m % 4, 12'hF00, 32'((m << 8) | m));
      chk("R6 swi map", req_col(m), 32'(m));
      chk("R6 swi only", 32'(cpu_irq), 32'(m));
      for (int c = 0; c < NCPU; c++)
        if (m[c]) wr(c, 12'h280, 32'(1 << m));
      chk("R6 swi cleared", 32'(cpu_irq), 32'd0);
    end

    // R4 banked pending
    wr(1, 12'h200, 32'h80);
    rd(1, 12'h200, d); chk("R4 pend own", d, 32'h80);
    rd(3, 12'h200, d); chk("R4 pend other", d, 32'h0);
    chk("R11 private home", 32'(cpu_irq), 32'h2);
    wr(1, 12'h280, 32'h80);

    // R10 private level line ID 20 on CPU 2
    @(negedge clk); ppi_in[2*16 + 4] = 1'b1;
    @(negedge clk);
    chk("R11 ppi cpu2", req_col(20), 32'h4);
    rd(2, 12'h200, d); chk("R4 ppi pend", d, 32'h0010_0000);
    wr(2, 12'h300, 32'h0010_0000);
    chk("R10 ppi active", 32'(cpu_irq), 32'd0);
    rd(0, 12'h300, d); chk("R4 act banked", d, 32'h0);
    rd(2, 12'h300, d); chk("R4 act own", d, 32'h0010_0000);
    wr(2, 12'h380, 32'h0010_0000);
    chk("R10 ppi back", 32'(cpu_irq), 32'h4);
    @(negedge clk); ppi_in[2*16 + 4] = 1'b0;
    @(negedge clk);
    chk("R10 ppi low", 32'(cpu_irq), 32'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule